// File: doc/BRIEF.md
# SCL Phase Timing Generator

This block turns the system clock into the serial-clock timing for a two-wire bus master. It holds a small state machine that walks through an idle state, a low phase, a high phase and a stretch state. It drives the SCL level and four single-cycle strobes to the protocol engine. The strobes mark where to change data, where to sample, and the setup points for a start condition and a stop condition. The protocol engine itself is a separate block and is not part of this one.

The timing comes straight from the raw control and address register words. A 12-bit divider is built from two fields that are not next to each other. A 12-bit low count sits in the address word, and one enable bit picks the scheme. With the enable at 0 the period is symmetric, about four times the divider plus a fixed 15-cycle allowance for the input sync path. With the enable at 1 the high phase is the divider plus 15 cycles and the low phase is the low count. The input glitch-filter fields in the address word are ignored, because the filters are bypassed. A target may hold SCL low after the block releases it. While that happens the high phase is stretched.

The state machine has these states. PH_IDLE holds SCL high while run is 0. The transition PH_IDLE→PH_LOW happens when run is 1. PH_LOW drives SCL low, and PH_LOW→PH_HIGH happens when its count ends. PH_HIGH releases SCL. PH_HIGH→PH_STRETCH happens when scl_in is sampled low, and PH_HIGH→PH_LOW happens when the high count ends. PH_STRETCH→PH_HIGH or PH_STRETCH→PH_LOW happens once scl_in reads high again. Every state returns to PH_IDLE when run falls.

Top module: `scl_timing_gen`

## Requirements
- R1: While run is 0 (and during reset), scl_out is 1 and all four strobes are 0; one cycle after run is sampled 0 the block is idle.
- R2: The divider D is {ctrl_word[29:28], ctrl_word[21:12]} (bits 29:28 are D[11:10]); no other ctrl_word bit changes the timing.
- R3: With addr_word[28]=0, each low phase lasts 2·D+7 cycles and each high phase 2·D+8 cycles (period 4·D+15).
- R4: With addr_word[28]=1, each high phase lasts D+15 cycles and each low phase lasts L cycles, where L = addr_word[27:16].
- R5: A D or L field of 0 is used as 1.
- R6: drive_stb pulses once per low phase, in the cycle whose zero-based index in that phase is floor(low/2).
- R7: Within a high phase of length H, counted zero-based over cycles with scl_in=1, stop_setup_stb pulses at index floor(H/4), sample_stb at floor(H/2) and start_setup_stb at floor(3H/4); at most one strobe is active in a cycle.
- R8: In the high phase a cycle with scl_in=0 does not advance the phase count, raises no strobe and keeps scl_out at 1.
- R9: addr_word bits [13:8] (filter settings) have no effect on any output.
- R10: When run is 1 in the idle state, the next cycle is the first cycle of a low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables clock generation |
| ctrl_word | input | 32 | Control register word (divider fields) |
| addr_word | input | 32 | Address register word (low count, split enable, filter fields) |
| scl_in | input | 1 | Synchronised SCL level seen on the bus |
| scl_out | output | 1 | SCL level to drive (1 = released) |
| drive_stb | output | 1 | Data-change point in the low phase |
| sample_stb | output | 1 | Data-sample point in the high phase |
| start_setup_stb | output | 1 | Start-condition setup point in the high phase |
| stop_setup_stb | output | 1 | Stop-condition setup point in the high phase |

## Verification
Clock stretching and the sample point can land in the same cycle. The bench holds scl_in low at several offsets in the high phase, including the cycle just before and the cycle at the sample index. Each time it checks that the sample strobe is held back while the line is low and then fires in the first released cycle whose count reaches the midpoint. A run drop one cycle long in the middle of a phase is also compared with the reference model on every clock.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_LOW     = 2'd1,
        PH_HIGH    = 2'd2,
        PH_STRETCH = 2'd3
    } scl_ph_e;

    localparam int unsigned REG_W = 32;

endpackage

// File: rtl/scl_field_decode.sv
module scl_field_decode
    import scl_gen_pkg::*;
#(
    parameter int unsigned DIV_W      = 12,
    parameter int unsigned LOW_W      = 12,
    parameter int unsigned DIV_LO_W   = 10,
    parameter int unsigned DIV_LO_POS = 12,
    parameter int unsigned DIV_HI_POS = 28,
    parameter int unsigned LOW_POS    = 16,
    parameter int unsigned SPLIT_POS  = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_W-1:0]    ctrl_word,
    input  logic [REG_W-1:0]    addr_word,
    output logic [DIV_W-1:0]    div_eff,
    output logic [LOW_W-1:0]    low_eff,
    output logic                split_mode
);
    localparam int unsigned DIV_HI_W = DIV_W - DIV_LO_W;

    logic [DIV_W-1:0] raw_div;
    logic [LOW_W-1:0] raw_low;
    logic             unused_fields;

    // The divider is assembled from two separate fields of the control word.
    assign raw_div = {ctrl_word[DIV_HI_POS +: DIV_HI_W], ctrl_word[DIV_LO_POS +: DIV_LO_W]};
    assign raw_low = addr_word[LOW_POS +: LOW_W];

    always_comb begin
        div_eff    = (raw_div == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : raw_div;
        low_eff    = (raw_low == '0) ? {{(LOW_W-1){1'b0}}, 1'b1} : raw_low;
        split_mode = addr_word[SPLIT_POS];
    end

    // The filter fields and all other bits are ignored on purpose.
    assign unused_fields = ^{ctrl_word, addr_word};

    // R5: the decoded counts are never zero
    a_r5_nonzero_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (div_eff != '0) && (low_eff != '0));

endmodule

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
    parameter int unsigned DIV_W      = 12,
    parameter int unsigned LOW_W      = 12,
    parameter int unsigned FILTER_DLY = 15,
    parameter int unsigned CNT_W      = DIV_W + 2
) (
    input  logic [DIV_W-1:0] div_eff,
    input  logic [LOW_W-1:0] low_eff,
    input  logic             split_mode,
    output logic [CNT_W-1:0] low_len,
    output logic [CNT_W-1:0] high_len,
    output logic [CNT_W-1:0] drive_pt,
    output logic [CNT_W-1:0] stop_pt,
    output logic [CNT_W-1:0] sample_pt,
    output logic [CNT_W-1:0] start_pt
);
    localparam int unsigned LOW_ADD  = FILTER_DLY / 2;
    localparam int unsigned HIGH_ADD = FILTER_DLY - LOW_ADD;

    logic [CNT_W-1:0] d_ext;
    logic [CNT_W-1:0] l_ext;
    logic [CNT_W-1:0] sym_low;
    logic [CNT_W-1:0] sym_high;
    logic [CNT_W-1:0] spl_low;
    logic [CNT_W-1:0] spl_high;
    logic [CNT_W+1:0] three_h;

    assign d_ext = CNT_W'(div_eff);
    assign l_ext = CNT_W'(low_eff);

    // Symmetric scheme: the 15-cycle allowance is shared between the two phases.
    assign sym_low  = (d_ext << 1) + CNT_W'(LOW_ADD);
    assign sym_high = (d_ext << 1) + CNT_W'(HIGH_ADD);
    // Split scheme: the allowance goes to the high phase only.
    assign spl_high = d_ext + CNT_W'(FILTER_DLY);
    assign spl_low  = l_ext;

    always_comb begin
        low_len  = split_mode ? spl_low  : sym_low;
        high_len = split_mode ? spl_high : sym_high;
    end

    assign three_h   = ({2'b00, high_len} << 1) + {2'b00, high_len};
    assign drive_pt  = low_len  >> 1;
    assign sample_pt = high_len >> 1;
    assign stop_pt   = high_len >> 2;
    assign start_pt  = three_h[CNT_W+1:2];

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] low_len,
    input  logic [CNT_W-1:0] high_len,
    input  logic [CNT_W-1:0] drive_pt,
    input  logic [CNT_W-1:0] stop_pt,
    input  logic [CNT_W-1:0] sample_pt,
    input  logic [CNT_W-1:0] start_pt,
    output logic             scl_out,
    output logic             drive_stb,
    output logic             sample_stb,
    output logic             start_setup_stb,
    output logic             stop_setup_stb
);
    scl_ph_e          st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             low_end;
    logic             high_end;
    logic             high_live;

    assign low_end   = (cnt_q >= low_len  - CNT_W'(1));
    assign high_end  = (cnt_q >= high_len - CNT_W'(1));
    assign high_live = ((st_q == PH_HIGH) || (st_q == PH_STRETCH)) && scl_in;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!run) begin
            st_d  = PH_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                PH_IDLE: begin
                    st_d  = PH_LOW;
                    cnt_d = '0;
                end
                PH_LOW: begin
                    if (low_end) begin
                        st_d  = PH_HIGH;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                PH_HIGH, PH_STRETCH: begin
                    if (!scl_in) begin
                        st_d = PH_STRETCH;
                    end else if (high_end) begin
                        st_d  = PH_LOW;
                        cnt_d = '0;
                    end else begin
                        st_d  = PH_HIGH;
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    st_d  = PH_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        scl_out         = 1'b1;
        drive_stb       = 1'b0;
        sample_stb      = 1'b0;
        start_setup_stb = 1'b0;
        stop_setup_stb  = 1'b0;
        unique case (st_q)
            PH_IDLE: ;
            PH_LOW: begin
                scl_out   = 1'b0;
                drive_stb = (cnt_q == drive_pt);
            end
            PH_HIGH, PH_STRETCH: begin
                stop_setup_stb  = high_live && (cnt_q == stop_pt);
                sample_stb      = high_live && (cnt_q == sample_pt);
                start_setup_stb = high_live && (cnt_q == start_pt);
            end
            default: ;
        endcase
    end

    // R1: dropping run returns the block to idle
    a_r1_idle_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (scl_out && !drive_stb && !sample_stb && !start_setup_stb && !stop_setup_stb));

    // R10: run in idle starts a low phase on the next cycle
    a_r10_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_IDLE && run) |=> (st_q == PH_LOW && cnt_q == '0));

    // R6: the data-change strobe only occurs while SCL is driven low
    a_r6_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        drive_stb |-> !scl_out);

    // R7: the high-phase strobes need a released and high line; never two at once
    a_r7_high_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb || start_setup_stb || stop_setup_stb) |-> (scl_out && scl_in));
    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drive_stb, sample_stb, start_setup_stb, stop_setup_stb}));

    // R8: a held-low line freezes the high count and keeps SCL released
    a_r8_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (st_q == PH_HIGH || st_q == PH_STRETCH) && !scl_in)
            |=> ($stable(cnt_q) && scl_out));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
    parameter int unsigned DIV_W      = 12,
    parameter int unsigned LOW_W      = 12,
    parameter int unsigned FILTER_DLY = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic [31:0] ctrl_word,
    input  logic [31:0] addr_word,
    input  logic        scl_in,
    output logic        scl_out,
    output logic        drive_stb,
    output logic        sample_stb,
    output logic        start_setup_stb,
    output logic        stop_setup_stb
);
    localparam int unsigned CNT_W = ((DIV_W > LOW_W) ? DIV_W : LOW_W) + 2;

    logic [DIV_W-1:0] div_eff;
    logic [LOW_W-1:0] low_eff;
    logic             split_mode;
    logic [CNT_W-1:0] low_len, high_len;
    logic [CNT_W-1:0] drive_pt, stop_pt, sample_pt, start_pt;

    scl_field_decode #(
        .DIV_W (DIV_W),
        .LOW_W (LOW_W)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_word  (ctrl_word),
        .addr_word  (addr_word),
        .div_eff    (div_eff),
        .low_eff    (low_eff),
        .split_mode (split_mode)
    );

    scl_phase_len #(
        .DIV_W      (DIV_W),
        .LOW_W      (LOW_W),
        .FILTER_DLY (FILTER_DLY),
        .CNT_W      (CNT_W)
    ) u_len (
        .div_eff    (div_eff),
        .low_eff    (low_eff),
        .split_mode (split_mode),
        .low_len    (low_len),
        .high_len   (high_len),
        .drive_pt   (drive_pt),
        .stop_pt    (stop_pt),
        .sample_pt  (sample_pt),
        .start_pt   (start_pt)
    );

    scl_phase_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .run             (run),
        .scl_in          (scl_in),
        .low_len         (low_len),
        .high_len        (high_len),
        .drive_pt        (drive_pt),
        .stop_pt         (stop_pt),
        .sample_pt       (sample_pt),
        .start_pt        (start_pt),
        .scl_out         (scl_out),
        .drive_stb       (drive_stb),
        .sample_stb      (sample_stb),
        .start_setup_stb (start_setup_stb),
        .stop_setup_stb  (stop_setup_stb)
    );

endmodule

// File: tb/scl_timing_gen_test.sv
`timescale 1ns/1ps
module scl_timing_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic [31:0] addr_word = '0;
    logic        hold = 1'b0;
    logic        scl_in;
    logic        scl_out, drive_stb, sample_stb, start_setup_stb, stop_setup_stb;

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    checking = 1'b0;
    bit    done = 1'b0;

    // model state: 0 idle, 1 low, 2 high
    int mph = 0;
    int mcnt = 0;

    always #2.5 clk = ~clk;

    assign scl_in = scl_out & ~hold;

    scl_timing_gen uut (
        .clk(clk), .rst_n(rst_n), .run(run), .ctrl_word(ctrl_word), .addr_word(addr_word),
        .scl_in(scl_in), .scl_out(scl_out), .drive_stb(drive_stb), .sample_stb(sample_stb),
        .start_setup_stb(start_setup_stb), .stop_setup_stb(stop_setup_stb)
    );

    function automatic int m_div();
        int d;
        d = int'((ctrl_word >> 12) & 32'h3FF) + (int'((ctrl_word >> 28) & 32'h3) * 1024);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic int m_low_len();
        int l;
        l = int'((addr_word >> 16) & 32'hFFF);
        if (l == 0) l = 1;
        return addr_word[28] ? l : 2 * m_div() + 7;
    endfunction

    function automatic int m_high_len();
        return addr_word[28] ? m_div() + 15 : 2 * m_div() + 8;
    endfunction

    function automatic logic [31:0] mk_ctrl(int d, logic [31:0] junk);
        logic [31:0] v;
        v = junk & 32'hCFC00FFF;
        v = v | (32'(d & 1023) << 12) | (32'((d >> 10) & 3) << 28);
        return v;
    endfunction

    function automatic logic [31:0] mk_addr(int l, bit split, int filt);
        return (32'(l & 4095) << 16) | (32'(split) << 28) | (32'(filt & 63) << 8);
    endfunction

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, act, exp);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        int ll, hl;
        bit line;
        ll = m_low_len();
        hl = m_high_len();
        line = (mph != 1) && !hold;
        if (!rst_n || !run) begin
            mph = 0; mcnt = 0;
        end else if (mph == 0) begin
            mph = 1; mcnt = 0;
        end else if (mph == 1) begin
            if (mcnt >= ll - 1) begin mph = 2; mcnt = 0; end
            else mcnt++;
        end else begin
            if (line) begin
                if (mcnt >= hl - 1) begin mph = 1; mcnt = 0; end
                else mcnt++;
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        int ll, hl;
        bit line;
        if (checking && !done) begin
            ll = m_low_len();
            hl = m_high_len();
            line = (mph != 1) && !hold;
            check("scl_out", int'(scl_out), (mph == 1) ? 0 : 1);
            check("drive_stb", int'(drive_stb), int'(mph == 1 && mcnt == ll / 2));
            check("stop_setup_stb", int'(stop_setup_stb), int'(mph == 2 && line && mcnt == hl / 4));
            check("sample_stb", int'(sample_stb), int'(mph == 2 && line && mcnt == hl / 2));
            check("start_setup_stb", int'(start_setup_stb), int'(mph == 2 && line && mcnt == (3 * hl) / 4));
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
        #0.5;
    endtask

    task automatic wait_high_at(int k);
        do @(negedge clk); while (!(mph == 2 && mcnt == k));
        #0.5;
    endtask

    task automatic summary();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL %s watchdog act=%0d exp=%0d", cur_req, 1, 0);
        summary();
    end

    initial begin
        int hl;
        // R1: reset state and idle with run low
        cur_req = "R1";
        cycles(1);
        checking = 1'b1;
        cycles(3);
        rst_n = 1'b1;
        ctrl_word = mk_ctrl(3, 0);
        cycles(10);

        // R3 with R6, R7: symmetric scheme, D=3 (low 13, high 14)
        cur_req = "R3";
        run = 1'b1;
        cycles(200);
        run = 1'b0;
        cycles(3);

        // R2: divider with upper field bits set and junk in all other control bits
        cur_req = "R2";
        ctrl_word = mk_ctrl(12'h401, 32'hFFFFFFFF);
        run = 1'b1;
        cycles(8400);
        run = 1'b0;
        cycles(3);

        // R4: split scheme, D=5 (high 20), L=30
        cur_req = "R4";
        ctrl_word = mk_ctrl(5, 0);
        addr_word = mk_addr(30, 1'b1, 0);
        run = 1'b1;
        cycles(300);
        run = 1'b0;
        cycles(3);

        // R9: same timing with every filter bit set
        cur_req = "R9";
        addr_word = mk_addr(30, 1'b1, 63);
        run = 1'b1;
        cycles(300);
        run = 1'b0;
        cycles(3);

        // R5: zero fields in split and symmetric schemes
        cur_req = "R5";
        ctrl_word = mk_ctrl(0, 32'h00000F0F);
        addr_word = mk_addr(0, 1'b1, 0);
        run = 1'b1;
        cycles(120);
        run = 1'b0;
        cycles(2);
        addr_word = mk_addr(0, 1'b0, 0);
        run = 1'b1;
        cycles(120);
        run = 1'b0;
        cycles(3);

        // R8 with R7: stretch at offsets around the sample point
        cur_req = "R8";
        ctrl_word = mk_ctrl(5, 0);
        addr_word = mk_addr(30, 1'b1, 0);
        hl = 20;
        run = 1'b1;
        for (int i = 0; i < 5; i++) begin
            int k;
            k = (i == 0) ? 0 : (i == 1) ? hl / 2 - 1 : (i == 2) ? hl / 2 :
                (i == 3) ? hl / 4 : hl - 1;
            wait_high_at(k);
            hold = 1'b1;
            cycles(7);
            hold = 1'b0;
            cycles(5);
        end
        cycles(60);
        run = 1'b0;
        cycles(3);

        // R10: short run drop in the middle of a phase, then restart
        cur_req = "R10";
        ctrl_word = mk_ctrl(3, 0);
        addr_word = '0;
        run = 1'b1;
        cycles(17);
        run = 1'b0;
        cycles(1);
        run = 1'b1;
        cycles(60);
        run = 1'b0;
        cycles(4);

        summary();
    end

endmodule